// File: doc/BRIEF.md
# Endpoint DMA Request Line Allocator

This block hands out a small pool of external DMA request lines to USB endpoints. A client issues one command per cycle: either allocate a line for an endpoint and direction, or release one. The block keeps a packed ownership register, with one field per request line, and answers every command exactly one cycle later with a done pulse and one of three outcomes: granted, busy, or error. A granted allocation also returns the line index and the trigger number the system DMA controller uses for that line.

Two operating modes exist. In multi-line mode every allocation claims the lowest free line of its own. In shared mode only line zero is used, and an endpoint may claim it only while no line is owned at all. A shared release is accepted only from the endpoint that holds line zero. The whole ownership register is always visible on a read port.

Top module: `ep_dmareq_alloc`

## Requirements
- R1: After reset the ownership register reads zero and no response is signalled.
- R2: Line i owns bits [5i+4:5i] of the ownership register; the endpoint number sits in the field's bits [3:0] and the transmit flag in bit 4.
- R3: In multi-line mode an allocation writes {tx, ep} into the lowest-indexed line whose endpoint subfield reads zero and returns that index with ok set.
- R4: Only lines 0 to 4 are ever granted; the field of line 5 stays zero. When lines 0 to 4 are all owned, an allocation responds busy and leaves the register unchanged.
- R5: An allocation for endpoint 0 responds with err set in either mode and leaves the register unchanged.
- R6: In shared mode an allocation succeeds only when the whole register is zero; it then writes {tx, ep} into line 0 and returns index 0. Otherwise it responds busy with no change.
- R7: In shared mode a release clears the whole register when its bits [3:0] equal the command's endpoint and responds ok; on a mismatch it responds err with the register unchanged.
- R8: In multi-line mode a release clears all five bits of the line given by cmd_line and responds ok; a line index of 5 or more responds err with no change.
- R9: A granted line index 0, 1, 2, 3, 4 returns trigger number 2, 3, 14, 15, 16 respectively; responses other than a granted allocation return index 0 and trigger 0.
- R10: rsp_done is high exactly in the cycle after a cycle with cmd_valid high, and then exactly one of rsp_ok, rsp_busy, rsp_err is high. Command encoding: cmd_op 0 allocates, 1 releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shared_mode | input | 1 | 1 selects shared single-line mode, 0 multi-line mode |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 allocate, 1 release |
| cmd_ep | input | 4 | Endpoint number |
| cmd_tx | input | 1 | Direction, 1 for transmit |
| cmd_line | input | 3 | Line to release in multi-line mode |
| rsp_done | output | 1 | Response valid pulse |
| rsp_ok | output | 1 | Command succeeded |
| rsp_busy | output | 1 | No line available |
| rsp_err | output | 1 | Command rejected |
| rsp_line | output | 3 | Granted line index |
| rsp_trigger | output | 7 | DMA controller trigger number of the granted line |
| map_rdata | output | 30 | Ownership register contents |

## Verification
The bench fills all five usable lines and then asks for a sixth; a design that scanned all six fields would grant line 5 and trigger 64 instead of answering busy. It frees a middle line and allocates again, which catches a finder that grants the highest or the next sequential line rather than the lowest free one. In shared mode it releases with a foreign endpoint, where a design missing the ownership check would wipe another endpoint's claim, and it requests endpoint 0 and an out-of-range release line, which a careless design would accept and corrupt the register. Random mixed commands across both modes are then compared field by field against a bench model.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    localparam int NUM_LINES    = 6;
    localparam int USABLE_LINES = 5;
    localparam int EP_W         = 4;
    localparam int FIELD_W      = EP_W + 1;
    localparam int MAP_W        = NUM_LINES * FIELD_W;
    localparam int LINE_W       = $clog2(NUM_LINES);
    localparam int TRIG_W       = 7;

    typedef enum logic {
        OP_ALLOC   = 1'b0,
        OP_RELEASE = 1'b1
    } op_e;

    typedef struct packed {
        logic              tx;
        logic [EP_W-1:0]   ep;
    } field_t;

    typedef struct packed {
        logic              ok;
        logic              busy;
        logic              err;
        logic [LINE_W-1:0] line;
    } resp_t;

    function automatic logic [TRIG_W-1:0] trigger_of(input logic [LINE_W-1:0] line);
        logic [TRIG_W-1:0] t;
        case (line)
            3'd0:    t = 7'd2;
            3'd1:    t = 7'd3;
            3'd2:    t = 7'd14;
            3'd3:    t = 7'd15;
            3'd4:    t = 7'd16;
            3'd5:    t = 7'd64;
            default: t = 7'd0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/dmareq_free_finder.sv
module dmareq_free_finder
    import dmareq_pkg::*;
#(
    parameter int LINES  = USABLE_LINES,
    parameter int FW     = FIELD_W,
    parameter int EW     = EP_W,
    parameter int MW     = MAP_W,
    parameter int LW     = LINE_W
) (
    input  logic [MW-1:0] map_i,
    output logic          found_o,
    output logic [LW-1:0] idx_o
);
    logic [LINES-1:0] free_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_free
        assign free_vec[g] = (map_i[g*FW +: EW] == '0);
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found_o = 1'b1;
                idx_o   = LW'(i);
            end
        end
    end

    // R3
    always_comb begin
        lowest_free_chk: assert (!found_o || (map_i[int'(idx_o)*FW +: EW] == '0));
    end

endmodule

// File: rtl/dmareq_trig_lut.sv
module dmareq_trig_lut
    import dmareq_pkg::*;
(
    input  logic [LINE_W-1:0] line_i,
    input  logic              en_i,
    output logic [TRIG_W-1:0] trig_o
);
    assign trig_o = en_i ? trigger_of(line_i) : '0;
endmodule

// File: rtl/dmareq_map_reg.sv
module dmareq_map_reg
    import dmareq_pkg::*;
#(
    parameter int MW = MAP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [MW-1:0] d_i,
    output logic [MW-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/ep_dmareq_alloc.sv
module ep_dmareq_alloc
    import dmareq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shared_mode,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [EP_W-1:0]   cmd_ep,
    input  logic              cmd_tx,
    input  logic [LINE_W-1:0] cmd_line,
    output logic              rsp_done,
    output logic              rsp_ok,
    output logic              rsp_busy,
    output logic              rsp_err,
    output logic [LINE_W-1:0] rsp_line,
    output logic [TRIG_W-1:0] rsp_trigger,
    output logic [MAP_W-1:0]  map_rdata
);
    logic [MAP_W-1:0]  map_q;
    logic [MAP_W-1:0]  map_nxt;
    logic              map_we;
    logic              free_found;
    logic [LINE_W-1:0] free_idx;
    resp_t             resp_nxt;
    logic              grant_nxt;
    logic [TRIG_W-1:0] trig_nxt;
    field_t            new_field;
    op_e               op;

    assign op        = op_e'(cmd_op);
    assign new_field = '{tx: cmd_tx, ep: cmd_ep};

    dmareq_free_finder u_finder (
        .map_i   (map_q),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    always_comb begin
        map_nxt   = map_q;
        resp_nxt  = '0;
        grant_nxt = 1'b0;
        if (op == OP_ALLOC) begin
            if (cmd_ep == '0) begin
                resp_nxt.err = 1'b1;
            end else if (shared_mode) begin
                if (map_q == '0) begin
                    map_nxt[FIELD_W-1:0] = new_field;
                    resp_nxt.ok          = 1'b1;
                    grant_nxt            = 1'b1;
                end else begin
                    resp_nxt.busy = 1'b1;
                end
            end else if (free_found) begin
                map_nxt[int'(free_idx)*FIELD_W +: FIELD_W] = new_field;
                resp_nxt.ok   = 1'b1;
                resp_nxt.line = free_idx;
                grant_nxt     = 1'b1;
            end else begin
                resp_nxt.busy = 1'b1;
            end
        end else begin
            if (shared_mode) begin
                if (map_q[EP_W-1:0] == cmd_ep) begin
                    map_nxt     = '0;
                    resp_nxt.ok = 1'b1;
                end else begin
                    resp_nxt.err = 1'b1;
                end
            end else if (int'(cmd_line) < USABLE_LINES) begin
                map_nxt[int'(cmd_line)*FIELD_W +: FIELD_W] = '0;
                resp_nxt.ok = 1'b1;
            end else begin
                resp_nxt.err = 1'b1;
            end
        end
    end

    assign map_we = cmd_valid;

    dmareq_trig_lut u_lut (
        .line_i (resp_nxt.line),
        .en_i   (grant_nxt),
        .trig_o (trig_nxt)
    );

    dmareq_map_reg u_map (
        .clk  (clk),
        .rst  (rst),
        .we_i (map_we),
        .d_i  (map_nxt),
        .q_o  (map_q)
    );

    logic rsp_alloc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done    <= 1'b0;
            rsp_ok      <= 1'b0;
            rsp_busy    <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_line    <= '0;
            rsp_trigger <= '0;
            rsp_alloc_q <= 1'b0;
        end else begin
            rsp_done    <= cmd_valid;
            rsp_ok      <= cmd_valid & resp_nxt.ok;
            rsp_busy    <= cmd_valid & resp_nxt.busy;
            rsp_err     <= cmd_valid & resp_nxt.err;
            rsp_line    <= cmd_valid ? resp_nxt.line : '0;
            rsp_trigger <= cmd_valid ? trig_nxt : '0;
            rsp_alloc_q <= cmd_valid & (op == OP_ALLOC);
        end
    end

    assign map_rdata = map_q;

    // R10
    resp_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_done);
    // R10
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_done);
    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> ($countones({rsp_ok, rsp_busy, rsp_err}) == 1));
    // R4
    sixth_line_idle_chk: assert property (@(posedge clk) disable iff (rst)
        map_q[MAP_W-1 -: FIELD_W] == '0);
    // R4
    grant_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_ok && rsp_alloc_q) |-> (int'(rsp_line) < USABLE_LINES));
    // R4
    busy_keeps_map_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_busy |-> (map_q == $past(map_q)));
    // R5
    err_keeps_map_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (map_q == $past(map_q)));
    // R9
    idle_trigger_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_ok && rsp_alloc_q) |-> (rsp_trigger == '0));

endmodule

// File: tb/ep_dmareq_alloc_tb.sv
module ep_dmareq_alloc_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        shared_mode, cmd_valid, cmd_op, cmd_tx;
    logic [3:0]  cmd_ep;
    logic [2:0]  cmd_line;
    logic        rsp_done, rsp_ok, rsp_busy, rsp_err;
    logic [2:0]  rsp_line;
    logic [6:0]  rsp_trigger;
    logic [29:0] map_rdata;

    int checks = 0;
    int fails  = 0;
    logic [29:0] model;

    always #5 clk = ~clk;

    ep_dmareq_alloc dut_i (
        .clk(clk), .rst(rst), .shared_mode(shared_mode), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_ep(cmd_ep), .cmd_tx(cmd_tx), .cmd_line(cmd_line),
        .rsp_done(rsp_done), .rsp_ok(rsp_ok), .rsp_busy(rsp_busy), .rsp_err(rsp_err),
        .rsp_line(rsp_line), .rsp_trigger(rsp_trigger), .map_rdata(map_rdata)
    );

    function automatic logic [6:0] exp_trig(input int l);
        case (l)
            0: return 7'd2;
            1: return 7'd3;
            2: return 7'd14;
            3: return 7'd15;
            4: return 7'd16;
            default: return 7'd0;
        endcase
    endfunction

    // expected {done, ok, busy, err, line, trigger, map}
    function automatic logic [45:0] predict(input logic sh, input logic op, input logic [3:0] ep,
                                            input logic tx, input logic [2:0] ln,
                                            inout logic [29:0] m, output string tag);
        logic ok = 0, bz = 0, er = 0;
        int   g = 0;
        logic [6:0] tr = 0;
        if (!op) begin
            if (ep == 0) begin er = 1; tag = "R5"; end
            else if (sh) begin
                tag = "R6";
                if (m == 0) begin m[4:0] = {tx, ep}; ok = 1; tr = exp_trig(0); end
                else bz = 1;
            end else begin
                tag = "R3";
                g = -1;
                for (int i = 4; i >= 0; i--) if (m[i*5 +: 4] == 0) g = i;
                if (g >= 0) begin m[g*5 +: 5] = {tx, ep}; ok = 1; tr = exp_trig(g); end
                else begin bz = 1; g = 0; tag = "R4"; end
            end
        end else begin
            if (sh) begin
                tag = "R7";
                if (m[3:0] == ep) begin m = 0; ok = 1; end else er = 1;
            end else begin
                tag = "R8";
                if (ln < 5) begin m[ln*5 +: 5] = 0; ok = 1; end else er = 1;
            end
        end
        return {1'b1, ok, bz, er, 3'(g), tr, m};
    endfunction

    task automatic check(input string tag, input logic [45:0] got, input logic [45:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic sh, input logic op, input logic [3:0] ep,
                         input logic tx, input logic [2:0] ln);
        logic [45:0] e;
        string tag;
        @(negedge clk);
        shared_mode = sh; cmd_valid = 1; cmd_op = op; cmd_ep = ep; cmd_tx = tx; cmd_line = ln;
        e = predict(sh, op, ep, tx, ln, model, tag);
        @(negedge clk);
        cmd_valid = 0;
        check(tag, {rsp_done, rsp_ok, rsp_busy, rsp_err, rsp_line, rsp_trigger, map_rdata}, e);
        if (!sh && !op && rsp_ok)
            check("R9", {39'd0, rsp_trigger}, {39'd0, exp_trig(int'(rsp_line))});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        rst = 1; cmd_valid = 0; cmd_op = 0; cmd_ep = 0; cmd_tx = 0; cmd_line = 0; shared_mode = 0;
        model = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", {rsp_done, 45'd0, map_rdata}, 76'd0);
        // R2 R3 fill all usable lines with mixed directions
        issue(0, 0, 4'd1, 1, 0);
        check("R2", {16'd0, map_rdata}, {16'd0, 25'd0, 5'b1_0001});
        issue(0, 0, 4'd2, 0, 0);
        issue(0, 0, 4'd3, 1, 0);
        issue(0, 0, 4'd4, 0, 0);
        issue(0, 0, 4'd5, 1, 0);
        // R4 no sixth line
        issue(0, 0, 4'd6, 1, 0);
        // R8 free middle line, R3 reuse it
        issue(0, 1, 4'd0, 0, 3'd2);
        issue(0, 0, 4'd7, 1, 0);
        // R5 endpoint zero
        issue(0, 0, 4'd0, 1, 0);
        // R8 invalid line
        issue(0, 1, 4'd0, 0, 3'd5);
        issue(0, 1, 4'd0, 0, 3'd7);
        for (int i = 0; i < 5; i++) issue(0, 1, 4'd0, 0, 3'(i));
        // R6 shared claim and contention
        issue(1, 0, 4'd9, 1, 0);
        issue(1, 0, 4'd3, 0, 0);
        // R7 foreign and owning release
        issue(1, 1, 4'd3, 0, 0);
        issue(1, 1, 4'd9, 0, 0);
        // R6 shared claim refused while a multi line is held
        issue(0, 0, 4'd4, 0, 0);
        issue(0, 0, 4'd5, 0, 0);
        issue(0, 1, 4'd0, 0, 3'd0);
        issue(1, 0, 4'd8, 1, 0);
        issue(0, 1, 4'd0, 0, 3'd1);
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic sh = ($urandom % 4) == 0;
            logic op = ($urandom % 5) < 2;
            logic [3:0] ep = 4'($urandom % 16);
            if (sh && op && ($urandom % 2)) ep = model[3:0];
            issue(sh, op, ep, 1'($urandom), 3'($urandom % 7));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule